// File: doc/BRIEF.md
# Cache Index Key Rotation Controller

This block owns the secret key that feeds the per-way index scrambling of a randomized cache. It loads a fresh key from a hardware random source after every reset. It replaces the key when a request arrives or when an interval of counted events runs out. The key cannot be read or written by software: the random source is its only origin.

A key change makes every resident line unreachable, so each change is in effect a full invalidation. The controller therefore orders the change against cache state. In write-back mode it first asks the cache to flush modified lines and waits until none remain. It then requests the invalidation, and it switches the key in the same edge that the invalidation completes. A programmable guard interval after each change keeps new changes from starting too soon. Triggers that arrive during the guard interval, or during a running change, are remembered and served later. While a change is in progress, `busy` stalls new cache accesses.

Top module: `rekey_ctrl`

## Requirements
- R1: While reset is held, `key_valid` is 0, `busy` is 1, and `drain_req` and `inv_req` are 0. After reset a key is loaded with no request applied.
- R2: Every key that becomes active equals the `rng_data` word captured at a rising clock edge where `rng_valid` and `rng_take` were both 1. Keys become active in the order they were captured.
- R3: When `wb_mode` is 0 at the start of a change, `drain_req` never rises and the sequence goes straight to invalidation. `drain_req` and `inv_req` are never high together.
- R4: When `wb_mode` is 1 at the start of a change, `drain_req` stays high until `drain_done` is seen with `cache_dirty` at 0. The key does not change while `cache_dirty` is 1.
- R5: The key changes only at the edge where `inv_done` is 1 while `inv_req` is 1. `inv_req` is raised only once a new random word has been captured.
- R6: `busy` is 1 from the cycle a change sequence starts until the edge where the new key becomes active. It is 0 in the cycle that shows the new key.
- R7: After a key activation, no new sequence starts until `min_gap` clock cycles have passed. A request made during that window is kept and served afterwards.
- R8: When `auto_period` is N (not 0), the N-th `event_tick` pulse after the last key activation triggers a change. When `auto_period` is 0, ticks trigger nothing.
- R9: With no request and no automatic trigger, the key and `key_valid` stay unchanged.
- R10: A request that arrives while a change is already running is held. It causes one more change after the running one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rng_valid | input | 1 | Random source has a word ready |
| rng_data | input | KEY_W | Random word |
| rng_take | output | 1 | Random word is captured at this edge |
| rekey_req | input | 1 | Request for a key change (pulse) |
| event_tick | input | 1 | Timer or performance event pulse |
| auto_period | input | CNT_W | Events per automatic change; 0 disables |
| min_gap | input | CNT_W | Minimum cycles between activations |
| wb_mode | input | 1 | 1 = write-back cache, 0 = write-through |
| cache_dirty | input | 1 | Cache still holds at least one modified line |
| drain_req | output | 1 | Ask the cache to write back all modified lines |
| drain_done | input | 1 | Cache finished the write-back pass |
| inv_req | output | 1 | Ask the cache to invalidate all lines |
| inv_done | input | 1 | Cache finished invalidation |
| key | output | KEY_W | Active index key |
| key_valid | output | 1 | A key has been loaded since reset |
| busy | output | 1 | Stall new cache accesses |

## Verification
The properties assume the cache follows the handshakes. It pulses `drain_done` and `inv_done` only while the matching request is high. It lowers `cache_dirty` before or together with `drain_done`, and it does not raise it again during a change. The bench's cache model answers each request after a fixed latency and sets the dirty flag only while the controller is idle. The random source is always valid and moves to a new word only after one is taken. Requests and event ticks are one-cycle pulses driven between clock edges, and the mode, interval and gap inputs change only when no change is running.

// File: rtl/rekey_pkg.sv
`timescale 1ns/1ps
package rekey_pkg;
    typedef enum logic [1:0] {
        RK_IDLE  = 2'd0,
        RK_DRAIN = 2'd1,
        RK_INVAL = 2'd2,
        RK_LOAD  = 2'd3
    } rk_state_e;
endpackage

// File: rtl/rk_gap_timer.sv
`timescale 1ns/1ps
module rk_gap_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] min_gap_i,
    output logic             blocked_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)
            cnt_d = '0;
        else if (cnt_q != CNT_MAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign blocked_o = (cnt_q < min_gap_i);

    // Counter restarts from zero after every activation.
    assert_gap_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/rk_auto_trigger.sv
`timescale 1ns/1ps
module rk_auto_trigger #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             fire_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             armed;

    assign armed  = (period_i != '0);
    assign fire_o = tick_i && armed && ({1'b0, cnt_q} + 1'b1 >= {1'b0, period_i});

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i || fire_o)
            cnt_d = '0;
        else if (tick_i && armed)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_fire_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (cnt_q == '0));
    assert_no_fire_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i == '0) |-> !fire_o);
endmodule

// File: rtl/rekey_ctrl.sv
`timescale 1ns/1ps
module rekey_ctrl
    import rekey_pkg::*;
#(
    parameter int KEY_W = 64,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rng_valid,
    input  logic [KEY_W-1:0] rng_data,
    output logic             rng_take,
    input  logic             rekey_req,
    input  logic             event_tick,
    input  logic [CNT_W-1:0] auto_period,
    input  logic [CNT_W-1:0] min_gap,
    input  logic             wb_mode,
    input  logic             cache_dirty,
    output logic             drain_req,
    input  logic             drain_done,
    output logic             inv_req,
    input  logic             inv_done,
    output logic [KEY_W-1:0] key,
    output logic             key_valid,
    output logic             busy
);
    typedef struct packed {
        rk_state_e        st;
        logic             pending;
        logic [KEY_W-1:0] key;
        logic             key_vld;
        logic [KEY_W-1:0] stage;
        logic             stage_vld;
    } rk_regs_t;

    rk_regs_t d, q;
    logic     activate;
    logic     gap_blocked;
    logic     auto_fire;
    logic     start_blocked;

    rk_gap_timer #(.CNT_W(CNT_W)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (activate),
        .min_gap_i (min_gap),
        .blocked_o (gap_blocked)
    );

    rk_auto_trigger #(.CNT_W(CNT_W)) u_auto (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (activate),
        .tick_i   (event_tick),
        .period_i (auto_period),
        .fire_o   (auto_fire)
    );

    // The first key after reset is never held back by the guard interval.
    assign start_blocked = q.key_vld && gap_blocked;

    always_comb begin
        d        = q;
        activate = 1'b0;
        rng_take = 1'b0;

        if (rekey_req || auto_fire)
            d.pending = 1'b1;

        if ((q.st == RK_DRAIN || q.st == RK_INVAL) && !q.stage_vld && rng_valid) begin
            d.stage     = rng_data;
            d.stage_vld = 1'b1;
            rng_take    = 1'b1;
        end

        unique case (q.st)
            RK_IDLE: begin
                if (q.pending && !start_blocked) begin
                    d.pending = rekey_req || auto_fire;
                    d.st      = wb_mode ? RK_DRAIN : RK_INVAL;
                end
            end
            RK_DRAIN: begin
                if (drain_done && !cache_dirty)
                    d.st = RK_INVAL;
            end
            RK_INVAL: begin
                if (q.stage_vld && inv_done) begin
                    d.key       = q.stage;
                    d.key_vld   = 1'b1;
                    d.stage_vld = 1'b0;
                    d.st        = RK_LOAD;
                    activate    = 1'b1;
                end
            end
            RK_LOAD: begin
                d.st = RK_IDLE;
            end
            default: d.st = RK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= RK_IDLE;
            q.pending   <= 1'b1;
            q.key       <= '0;
            q.key_vld   <= 1'b0;
            q.stage     <= '0;
            q.stage_vld <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign drain_req = (q.st == RK_DRAIN);
    assign inv_req   = (q.st == RK_INVAL) && q.stage_vld;
    assign key       = q.key;
    assign key_valid = q.key_vld;
    assign busy      = !q.key_vld || (q.st == RK_DRAIN) || (q.st == RK_INVAL);

    assert_key_on_inv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.key) |-> ($past(inv_done) && $past(inv_req)));
    assert_drain_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == RK_INVAL) && ($past(q.st) == RK_DRAIN)) |-> !$past(cache_dirty));
    assert_wt_skips_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == RK_IDLE) && !wb_mode) |=> (q.st != RK_DRAIN));
    assert_one_handshake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drain_req, inv_req}));
    assert_gap_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == RK_IDLE) && start_blocked) |=> (q.st == RK_IDLE));
    assert_busy_no_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |-> busy);
endmodule

// File: tb/sim_rekey_ctrl.sv
`timescale 1ns/1ps
module sim_rekey_ctrl;
    localparam int KEY_W = 64;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rng_valid = 1'b1;
    logic [KEY_W-1:0] rng_data = 64'h0123_4567_89AB_CDEF;
    logic             rng_take;
    logic             rekey_req = 1'b0;
    logic             event_tick = 1'b0;
    logic [CNT_W-1:0] auto_period = '0;
    logic [CNT_W-1:0] min_gap = 16'd20;
    logic             wb_mode = 1'b0;
    logic             cache_dirty = 1'b0;
    logic             drain_req;
    logic             drain_done = 1'b0;
    logic             inv_req;
    logic             inv_done = 1'b0;
    logic [KEY_W-1:0] key;
    logic             key_valid;
    logic             busy;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int act_count = 0;
    int act_cycle = 0;
    int act_prev  = 0;
    bit inv_seen = 0;
    bit drain_seen = 0;
    bit exp_drain = 0;
    logic [KEY_W-1:0] prev_key = '0;
    bit prev_vld = 0;
    logic [KEY_W-1:0] exp_q[$];

    always #10 clk = ~clk;

    rekey_ctrl #(.KEY_W(KEY_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .rng_valid(rng_valid), .rng_data(rng_data),
        .rng_take(rng_take), .rekey_req(rekey_req), .event_tick(event_tick),
        .auto_period(auto_period), .min_gap(min_gap), .wb_mode(wb_mode),
        .cache_dirty(cache_dirty), .drain_req(drain_req), .drain_done(drain_done),
        .inv_req(inv_req), .inv_done(inv_done), .key(key), .key_valid(key_valid),
        .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [KEY_W-1:0] actual,
                       input logic [KEY_W-1:0] expected);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, actual, expected);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Driver side of the scoreboard: each captured random word is expected as a key.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rng_take) begin
                exp_q.push_back(rng_data);
                @(posedge clk);
                #1 rng_data = {rng_data[62:0], rng_data[63] ^ rng_data[61]} ^ 64'h9E37_79B9_7F4A_7C15;
            end
        end
    end

    // Cache model: answers drain after 6 cycles, invalidate after 4.
    initial begin
        int dcnt = 0;
        int icnt = 0;
        forever begin
            @(negedge clk);
            if (drain_done) drain_done = 1'b0;
            else if (drain_req) begin
                dcnt++;
                if (dcnt == 6) begin
                    drain_done  = 1'b1;
                    cache_dirty = 1'b0;
                    dcnt = 0;
                end
            end else dcnt = 0;
            if (inv_done) inv_done = 1'b0;
            else if (inv_req) begin
                icnt++;
                if (icnt == 4) begin
                    inv_done = 1'b1;
                    icnt = 0;
                end
            end else icnt = 0;
        end
    end

    // Monitor side of the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (inv_req) inv_seen = 1;
                if (drain_req) drain_seen = 1;
                if (key_valid && (!prev_vld || key != prev_key)) begin
                    if (exp_q.size() == 0)
                        chk(0, "R2 key without captured word", key, '0);
                    else begin
                        logic [KEY_W-1:0] e;
                        e = exp_q.pop_front();
                        chk(key == e, "R2 key value", key, e);
                    end
                    chk(busy == 1'b0, "R6 busy low at activation", {63'd0, busy}, '0);
                    chk(inv_seen, "R5 invalidate before key", {63'd0, inv_seen}, 64'd1);
                    chk(drain_seen == exp_drain, "R3/R4 drain use", {63'd0, drain_seen}, {63'd0, exp_drain});
                    chk(cache_dirty == 1'b0, "R4 clean at key change", {63'd0, cache_dirty}, '0);
                    act_prev  = act_cycle;
                    act_cycle = cyc;
                    act_count++;
                    inv_seen = 0;
                    drain_seen = 0;
                end
                prev_key = key;
                prev_vld = key_valid;
            end
        end
    end

    task automatic pulse_req();
        @(negedge clk) rekey_req = 1'b1;
        @(negedge clk) rekey_req = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk) event_tick = 1'b1;
        @(negedge clk) event_tick = 1'b0;
    endtask

    task automatic wait_act(input int target);
        while (act_count < target) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [KEY_W-1:0] kb;
        int ab;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(key_valid == 1'b0, "R1 key_valid in reset", {63'd0, key_valid}, '0);
        chk(busy == 1'b1, "R1 busy in reset", {63'd0, busy}, 64'd1);
        chk(!drain_req && !inv_req, "R1 handshakes idle", {62'd0, drain_req, inv_req}, '0);
        rst_n = 1'b1;

        // R1: boot key without a request
        wait_act(1);
        chk(key_valid == 1'b1, "R1 boot key loaded", {63'd0, key_valid}, 64'd1);

        // R9: quiet period keeps the key
        kb = key;
        repeat (50) @(negedge clk);
        chk(key == kb, "R9 key stable without trigger", key, kb);
        chk(act_count == 1, "R9 no activation", act_count, 1);

        // R3: write-through change
        exp_drain = 0;
        pulse_req();
        @(negedge clk);
        chk(busy == 1'b1, "R6 busy during change", {63'd0, busy}, 64'd1);
        wait_act(2);

        // R4: write-back with dirty lines
        repeat (30) @(negedge clk);
        wb_mode = 1'b1;
        exp_drain = 1;
        cache_dirty = 1'b1;
        kb = key;
        pulse_req();
        repeat (3) @(negedge clk);
        chk(drain_req == 1'b1, "R4 drain requested", {63'd0, drain_req}, 64'd1);
        chk(key == kb, "R4 key held while dirty", key, kb);
        wait_act(3);

        // R7: request right after activation waits for the guard interval
        pulse_req();
        wait_act(4);
        chk((act_cycle - act_prev) > 20, "R7 guard interval", act_cycle - act_prev, 21);

        // R10: request during a running change is kept
        repeat (30) @(negedge clk);
        cache_dirty = 1'b1;
        ab = act_count;
        pulse_req();
        while (!drain_req) @(negedge clk);
        pulse_req();
        wait_act(ab + 2);
        chk(act_count == ab + 2, "R10 second change served", act_count, ab + 2);
        repeat (40) @(negedge clk);
        chk(act_count == ab + 2, "R10 exactly one extra change", act_count, ab + 2);

        // R8: automatic trigger on event count
        wb_mode = 1'b0;
        exp_drain = 0;
        min_gap = 16'd2;
        auto_period = 16'd5;
        ab = act_count;
        repeat (4) pulse_tick();
        repeat (20) @(negedge clk);
        chk(act_count == ab, "R8 no change before N ticks", act_count, ab);
        pulse_tick();
        repeat (40) @(negedge clk);
        chk(act_count == ab + 1, "R8 change on N-th tick", act_count, ab + 1);
        auto_period = '0;
        repeat (8) pulse_tick();
        repeat (30) @(negedge clk);
        chk(act_count == ab + 1, "R8 disabled when period is 0", act_count, ab + 1);
        chk(exp_q.size() == 0, "R2 all captured words used", exp_q.size(), 0);

        finish_run();
    end
endmodule